// File: doc/BRIEF.md
# Instruction-Dependent Program Counter Strobe Generator

This block sets the update rate of the program counter in a datapath where each instruction needs its own number of base-clock cycles. A free-running base clock drives a down-counter. At each instruction boundary the counter is reloaded with a cycle count, and that count is chosen from the opcode of the instruction that is starting. When the count is used up, the block flags the last base cycle of the instruction. On the next cycle it raises a one-cycle strobe, which the datapath uses as its program counter clock enable.

Opcodes fall into six classes: register-format, load word, store word, conditional branch, jump, and everything else. Each class has its own count, set by a parameter. Unknown opcodes get the longest count, so a slow instruction is never cut short. The opcode is read only at a reload edge. Changes between reloads do not affect the period that is already running.

Top module: `pc_strobe_gen`

## Requirements
- R1: While rst_ni is low, tc_o and pc_stb_o are both low.
- R2: Opcode 6'b000000 (register format) gives an instruction period of 4 base cycles, so pc_stb_o pulses are 4 cycles apart.
- R3: Opcode 6'b100011 (load word) gives a period of 5 base cycles.
- R4: Opcode 6'b101011 (store word) gives a period of 4 base cycles.
- R5: Opcodes 6'b000100 and 6'b000101 (branches) give a period of 3 base cycles.
- R6: Opcodes 6'b000010 and 6'b000011 (jumps) give a period of 1 base cycle. With a jump held on opcode_i, tc_o and pc_stb_o stay high on every cycle.
- R7: Any other opcode gives the longest period, 5 base cycles.
- R8: opcode_i is sampled only at the rising edge that ends an instruction (the edge where tc_o is high), plus the first edge after reset. Opcode changes at any other edge do not change the running period.
- R9: The first rising edge after reset release loads the count for the opcode present at that edge. For a count N, tc_o first goes high after N rising edges, counting the loading edge.
- R10: tc_o is high for exactly the last base cycle of each instruction. pc_stb_o is high for exactly the one cycle that follows each tc_o cycle, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 6 | Opcode field of the current instruction |
| tc_o | output | 1 | High during the last base cycle of the instruction |
| pc_stb_o | output | 1 | One-cycle program counter update strobe |

## Verification
The hardest case to reach from the ports is an opcode that changes in the middle of an instruction, and especially one that changes on the very edge that reloads the counter. A wrong design that samples opcode_i one cycle early or late gives the same waveforms whenever the opcode is held steady. The random phase therefore draws a new opcode on every cycle, mixing the listed opcodes with arbitrary values. A cycle-level reference model then checks tc_o and pc_stb_o on every cycle. Directed phases hold each opcode class for several instructions and measure the spacing between strobes. They also cover the first load after reset and back-to-back jumps, where the count of 1 keeps both outputs high.

// File: rtl/pcgen_pkg.sv
package pcgen_pkg;

  typedef enum logic [2:0] {
    CLS_RTYPE,
    CLS_LOAD,
    CLS_STORE,
    CLS_BRANCH,
    CLS_JUMP,
    CLS_OTHER
  } instr_cls_e;

  localparam int unsigned OP_W = 6;

  localparam logic [OP_W-1:0] OP_RTYPE = 6'b000000;
  localparam logic [OP_W-1:0] OP_LOAD  = 6'b100011;
  localparam logic [OP_W-1:0] OP_STORE = 6'b101011;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'b000100;
  localparam logic [OP_W-1:0] OP_BNE   = 6'b000101;
  localparam logic [OP_W-1:0] OP_JMP   = 6'b000010;
  localparam logic [OP_W-1:0] OP_JAL   = 6'b000011;

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pcgen_classify.sv
module pcgen_classify
  import pcgen_pkg::*;
(
  input  logic [OP_W-1:0] opcode_i,
  output instr_cls_e      cls_o
);

  always_comb begin
    case (opcode_i)
      OP_RTYPE:        cls_o = CLS_RTYPE;
      OP_LOAD:         cls_o = CLS_LOAD;
      OP_STORE:        cls_o = CLS_STORE;
      OP_BEQ, OP_BNE:  cls_o = CLS_BRANCH;
      OP_JMP, OP_JAL:  cls_o = CLS_JUMP;
      default:         cls_o = CLS_OTHER;
    endcase
  end

endmodule

// File: rtl/pcgen_period_sel.sv
module pcgen_period_sel
  import pcgen_pkg::*;
#(
  parameter int unsigned CNT_W      = 3,
  parameter int unsigned RTYPE_CYC  = 4,
  parameter int unsigned LOAD_CYC   = 5,
  parameter int unsigned STORE_CYC  = 4,
  parameter int unsigned BRANCH_CYC = 3,
  parameter int unsigned JUMP_CYC   = 1,
  parameter int unsigned DEF_CYC    = 5
) (
  input  instr_cls_e       cls_i,
  output logic [CNT_W-1:0] cyc_o
);

  always_comb begin
    case (cls_i)
      CLS_RTYPE:  cyc_o = CNT_W'(RTYPE_CYC);
      CLS_LOAD:   cyc_o = CNT_W'(LOAD_CYC);
      CLS_STORE:  cyc_o = CNT_W'(STORE_CYC);
      CLS_BRANCH: cyc_o = CNT_W'(BRANCH_CYC);
      CLS_JUMP:   cyc_o = CNT_W'(JUMP_CYC);
      default:    cyc_o = CNT_W'(DEF_CYC);
    endcase
  end

endmodule

// File: rtl/pcgen_counter.sv
module pcgen_counter #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tc_o,
  output logic             stb_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             stb_q;
  logic             reload;

  // zero only after reset: forces the first load from the live opcode
  assign reload = (cnt_q <= CNT_W'(1));
  assign tc_o   = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      stb_q <= 1'b0;
    end else begin
      cnt_q <= reload ? load_val_i : cnt_q - CNT_W'(1);
      stb_q <= tc_o;
    end
  end

  assign cnt_o = cnt_q;
  assign stb_o = stb_q;

endmodule

// File: rtl/pc_strobe_gen.sv
module pc_strobe_gen
  import pcgen_pkg::*;
#(
  parameter int unsigned RTYPE_CYC  = 4,
  parameter int unsigned LOAD_CYC   = 5,
  parameter int unsigned STORE_CYC  = 4,
  parameter int unsigned BRANCH_CYC = 3,
  parameter int unsigned JUMP_CYC   = 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_W-1:0] opcode_i,
  output logic            tc_o,
  output logic            pc_stb_o
);

  localparam int unsigned MAX_CYC = max_of(max_of(max_of(RTYPE_CYC, LOAD_CYC),
                                                  max_of(STORE_CYC, BRANCH_CYC)), JUMP_CYC);
  localparam int unsigned DEF_CYC = MAX_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  instr_cls_e       cls_w;
  logic [CNT_W-1:0] load_val_w;
  logic [CNT_W-1:0] cnt_w;

  pcgen_classify u_classify (
    .opcode_i (opcode_i),
    .cls_o    (cls_w)
  );

  pcgen_period_sel #(
    .CNT_W      (CNT_W),
    .RTYPE_CYC  (RTYPE_CYC),
    .LOAD_CYC   (LOAD_CYC),
    .STORE_CYC  (STORE_CYC),
    .BRANCH_CYC (BRANCH_CYC),
    .JUMP_CYC   (JUMP_CYC),
    .DEF_CYC    (DEF_CYC)
  ) u_period_sel (
    .cls_i (cls_w),
    .cyc_o (load_val_w)
  );

  pcgen_counter #(
    .CNT_W (CNT_W)
  ) u_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_val_i (load_val_w),
    .cnt_o      (cnt_w),
    .tc_o       (tc_o),
    .stb_o      (pc_stb_o)
  );

endmodule

// File: rtl/pc_strobe_gen_chk.sv
module pc_strobe_gen_chk
  import pcgen_pkg::*;
#(
  parameter int unsigned CNT_W      = 3,
  parameter int unsigned LOAD_CYC   = 5,
  parameter int unsigned BRANCH_CYC = 3,
  parameter int unsigned JUMP_CYC   = 1,
  parameter int unsigned DEF_CYC    = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [OP_W-1:0]  opcode_i,
  input logic             tc_i,
  input logic             stb_i,
  input logic [CNT_W-1:0] cnt_i
);

  logic at_load;
  logic known_op;
  assign at_load  = (cnt_i <= CNT_W'(1));
  assign known_op = (opcode_i == OP_RTYPE) || (opcode_i == OP_LOAD) || (opcode_i == OP_STORE) ||
                    (opcode_i == OP_BEQ) || (opcode_i == OP_BNE) ||
                    (opcode_i == OP_JMP) || (opcode_i == OP_JAL);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_quiet_R1: assert (!tc_i && !stb_i);
    end
  end

  assert_load_lw_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_load && opcode_i == OP_LOAD) |=> (int'(cnt_i) == int'(LOAD_CYC)));

  assert_load_branch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_load && (opcode_i == OP_BEQ || opcode_i == OP_BNE)) |=> (int'(cnt_i) == int'(BRANCH_CYC)));

  assert_load_default_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_load && !known_op) |=> (int'(cnt_i) == int'(DEF_CYC)));

  assert_count_down_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i > CNT_W'(1)) |=> (cnt_i == $past(cnt_i) - CNT_W'(1)));

  assert_stb_after_tc_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_i |=> stb_i);

  assert_stb_only_after_tc_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tc_i |=> !stb_i);

  generate
    if (JUMP_CYC == 1) begin : g_jump_single
      assert_jump_repeat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tc_i && (opcode_i == OP_JMP || opcode_i == OP_JAL)) |=> tc_i);
    end
  endgenerate

endmodule

bind pc_strobe_gen pc_strobe_gen_chk #(
  .CNT_W      (CNT_W),
  .LOAD_CYC   (LOAD_CYC),
  .BRANCH_CYC (BRANCH_CYC),
  .JUMP_CYC   (JUMP_CYC),
  .DEF_CYC    (DEF_CYC)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .opcode_i (opcode_i),
  .tc_i     (tc_o),
  .stb_i    (pc_stb_o),
  .cnt_i    (cnt_w)
);

// File: tb/pc_strobe_gen_tb_top.sv
module pc_strobe_gen_tb_top;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] opcode_i = 6'b000000;
  logic       tc_o;
  logic       pc_stb_o;

  int n_cmp = 0;
  int n_bad = 0;
  int m_cnt = 0;
  bit m_stb = 1'b0;
  int cyc_idx = 0;
  int last_stb = -1;
  int hold_start = 0;
  bit hold_on = 1'b0;
  logic [5:0] held_op = '0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  pc_strobe_gen dut_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .opcode_i (opcode_i),
    .tc_o     (tc_o),
    .pc_stb_o (pc_stb_o)
  );

  function automatic int exp_period(input logic [5:0] op);
    case (op)
      6'b000000: return 4;
      6'b100011: return 5;
      6'b101011: return 4;
      6'b000100, 6'b000101: return 3;
      6'b000010, 6'b000011: return 1;
      default: return 5;
    endcase
  endfunction

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc_idx);
    end
  endtask

  // called just after a falling edge: check, drive, advance model to the next edge
  task automatic cycle(input logic [5:0] op, input string tag);
    cmp(tag, "tc_o", int'(tc_o), int'(m_cnt == 1));
    cmp("R10", "pc_stb_o", int'(pc_stb_o), int'(m_stb));
    if (pc_stb_o) begin
      if (hold_on && last_stb > hold_start)
        cmp(tag, "strobe spacing", cyc_idx - last_stb, exp_period(held_op));
      last_stb = cyc_idx;
    end
    opcode_i = op;
    m_stb = (m_cnt == 1);
    if (m_cnt <= 1) m_cnt = exp_period(op);
    else m_cnt = m_cnt - 1;
    cyc_idx++;
    @(negedge clk_i);
  endtask

  task automatic hold(input logic [5:0] op, input int n, input string tag);
    hold_on = 1'b1;
    hold_start = cyc_idx;
    held_op = op;
    for (int i = 0; i < n; i++) cycle(op, tag);
    hold_on = 1'b0;
  endtask

  function automatic logic [5:0] pick_op();
    int unsigned r;
    r = $urandom_range(0, 9);
    case (r)
      0: return 6'b000000;
      1: return 6'b100011;
      2: return 6'b101011;
      3: return 6'b000100;
      4: return 6'b000101;
      5: return 6'b000010;
      6: return 6'b000011;
      default: return 6'($urandom);
    endcase
  endfunction

  initial begin
    void'($urandom(32'h5EED_0042));
    // R1: outputs quiet in reset, even with opcodes toggling
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      opcode_i = (i % 2 == 0) ? 6'b000010 : 6'b100011;
      cmp("R1", "tc_o in reset", int'(tc_o), 0);
      cmp("R1", "pc_stb_o in reset", int'(pc_stb_o), 0);
    end
    @(negedge clk_i);
    opcode_i = 6'b100011;
    rst_ni = 1'b1;
    m_cnt = 0;
    m_stb = 1'b0;
    hold(6'b100011, 8, "R9");
    hold(6'b100011, 20, "R3");
    hold(6'b000000, 20, "R2");
    hold(6'b101011, 20, "R4");
    hold(6'b000100, 15, "R5");
    hold(6'b000101, 15, "R5");
    hold(6'b000010, 6, "R6");
    hold(6'b000011, 6, "R6");
    hold(6'b111111, 20, "R7");
    hold(6'b001000, 20, "R7");
    // R8 directed: load word started, then a jump appears mid-instruction
    hold(6'b100011, 6, "R8");
    for (int i = 0; i < 4; i++) cycle(6'b000010, "R8");
    for (int i = 0; i < 8; i++) cycle(6'b000100, "R8");
    // R8 random: opcode changes every cycle
    for (int i = 0; i < 3000; i++) cycle(pick_op(), "R8");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule